// File: doc/BRIEF.md
# Packed Element Interleave Unit

This unit takes two 64-bit packed operands and builds a 64-bit result by alternating their elements. An element is 1, 2 or 4 bytes wide, and both operands and the result use the same element width. Only one half of each operand feeds the result. A half-select input picks either the low-order half or the high-order half. Within that half, element i of the first operand goes to result slot 2i, and element i of the second operand goes to slot 2i+1.

The unit has one register stage. A request presented with `in_valid` high produces its result and a result strobe on the next clock edge. The output register loads only on a valid request and otherwise keeps its contents. A lane-size code that names 8-byte elements would leave no elements in a half. Such a request returns an all-zero result and raises an error flag. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `pkilv_unit`

## Requirements
- R1: While reset is asserted, and after it is released, until the first valid request, `out_valid`, `out_size_err` and `out_data` are all 0.
- R2: `out_valid` is 1 in the cycle after a clock edge where `in_valid` was 1, and 0 in the cycle after an edge where `in_valid` was 0.
- R3: `lane_size` selects the element width: code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes. Each half then holds 4, 2 or 1 elements respectively.
- R4: With `upper_sel` = 0, result slot 2i holds element i of `src_a`, and slot 2i+1 holds element i of `src_b`, for i from 0 to half the lane count minus 1. Slot 0 is the least significant element.
- R5: With `upper_sel` = 1, the elements used are those whose index starts at half the lane count (bits 63:32 of each operand). They land in the same slot order as in R4.
- R6: Every bit of `out_data` is rewritten by each valid request. Nothing from the previous result survives.
- R7: `lane_size` code 3 (8 bytes) is illegal. A valid request with it gives `out_size_err` = 1 and `out_data` = 0, regardless of `upper_sel`. A legal code gives `out_size_err` = 0.
- R8: When `in_valid` is 0, operand, size and half-select changes are ignored: `out_data` and `out_size_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 64 | First operand, feeds even slots |
| src_b | input | 64 | Second operand, feeds odd slots |
| lane_size | input | 2 | Element width code (0:1B, 1:2B, 2:4B, 3:illegal) |
| upper_sel | input | 1 | 0 selects the low halves, 1 the high halves |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 64 | Interleaved result |
| out_size_err | output | 1 | Illegal element width on the captured request |

## Verification
The operand pair uses a distinct value in every byte, so each byte carries its own index and source. A misplaced slot, a swapped source or the wrong half shows up as a wrong byte value. That pair is run at every width code with both half-selects. Separate all-ones and all-zero operands are used to check bit coverage within an element and to show that a zero result clears an earlier all-ones one. Idle cycles with changing inputs, back-to-back requests and the illegal width code check the strobe timing, the hold behaviour and the error path.

// File: rtl/pkilv_pkg.sv
package pkilv_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned SIZE_W    = 2;
  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned BYTE_W    = 8;

  typedef enum logic [SIZE_W-1:0] {
    LANE_1B = 2'd0,
    LANE_2B = 2'd1,
    LANE_4B = 2'd2,
    LANE_8B = 2'd3
  } lane_size_e;
endpackage

// File: rtl/pkilv_rst_sync.sv
module pkilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pkilv_size_dec.sv
module pkilv_size_dec
  import pkilv_pkg::*;
#(
  parameter int unsigned N_SIZES = NUM_SIZES
) (
  input  logic [SIZE_W-1:0]  size_code,
  output logic [N_SIZES-1:0] size_oh,
  output logic               size_bad
);
  always_comb begin
    size_oh  = '0;
    size_bad = 1'b0;
    if (int'(size_code) < int'(N_SIZES)) begin
      size_oh[size_code] = 1'b1;
    end else begin
      size_bad = 1'b1;
    end
  end

  always_comb begin
    assert (!(size_bad && (size_oh != '0)))
      else $error("p_bad_no_select_r7: illegal code also selected a width");
  end
endmodule

// File: rtl/pkilv_weave.sv
module pkilv_weave #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              upper_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned LANES  = DATA_W / ELEM_W;
  localparam int unsigned HALF   = LANES / 2;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] a_half;
  logic [HALF_W-1:0] b_half;

  always_comb begin
    if (upper_i) begin
      a_half = a_i[DATA_W-1 -: HALF_W];
      b_half = b_i[DATA_W-1 -: HALF_W];
    end else begin
      a_half = a_i[HALF_W-1:0];
      b_half = b_i[HALF_W-1:0];
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign res_o[(2*i)*ELEM_W +: ELEM_W]   = a_half[i*ELEM_W +: ELEM_W];
    assign res_o[(2*i+1)*ELEM_W +: ELEM_W] = b_half[i*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/pkilv_unit.sv
module pkilv_unit
  import pkilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [SIZE_W-1:0] lane_size,
  input  logic              upper_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_size_err
);
  logic rst_sync_n;

  pkilv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [NUM_SIZES-1:0] size_oh;
  logic                 size_bad;

  pkilv_size_dec #(.N_SIZES(NUM_SIZES)) u_dec (
    .size_code (lane_size),
    .size_oh   (size_oh),
    .size_bad  (size_bad)
  );

  logic [DATA_W-1:0] weave_res [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
    pkilv_weave #(
      .DATA_W (DATA_W),
      .ELEM_W (BYTE_W << k)
    ) u_weave (
      .a_i     (src_a),
      .b_i     (src_b),
      .upper_i (upper_sel),
      .res_o   (weave_res[k])
    );
  end

  // next-state logic
  logic              load_en;
  logic [DATA_W-1:0] data_d;
  logic              err_d;
  logic              valid_d;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    err_d   = size_bad;
    data_d  = '0;
    for (int k = 0; k < int'(NUM_SIZES); k++) begin
      if (size_oh[k]) begin
        data_d = data_d | weave_res[k];
      end
    end
  end

  // registers
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        data_q <= data_d;
        err_q  <= err_d;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign out_size_err = err_q;

  // R2: strobe follows the request by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R8: idle cycles leave the result untouched
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_data) && $stable(out_size_err)));

  // R7: illegal width gives a flagged zero result
  p_bad_size_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && lane_size == LANE_8B) |=> (out_size_err && out_data == '0));
  p_good_size_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && lane_size != LANE_8B) |=> !out_size_err);

  // R4: lowest byte slot takes the lowest byte of the first operand
  p_low_slot0_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && lane_size == LANE_1B && !upper_sel)
      |=> (out_data[7:0] == $past(src_a[7:0])));

  // R5: top byte slot takes the top byte of the second operand
  p_high_slot_top_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && lane_size == LANE_1B && upper_sel)
      |=> (out_data[63:56] == $past(src_b[63:56])));
endmodule

// File: tb/sim_pkilv_unit.sv
module sim_pkilv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  localparam logic [63:0] VA = 64'h0706050403020100;
  localparam logic [63:0] VB = 64'h1716151413121110;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam logic [63:0] T_A [NVEC] = '{VA, VA, VA, VA, VA, VA, VA,
    ONES, 64'hFFFF_FFFF_0000_0000, 64'h0};
  localparam logic [63:0] T_B [NVEC] = '{VB, VB, VB, VB, VB, VB, VB,
    64'h0, 64'h0, ONES};
  localparam logic [1:0]  T_S [NVEC] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2,
    2'd3, 2'd0, 2'd2, 2'd1};
  localparam logic        T_U [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [63:0] T_E [NVEC] = '{
    64'h1303_1202_1101_1000, 64'h1707_1606_1505_1404,
    64'h1312_0302_1110_0100, 64'h1716_0706_1514_0504,
    64'h1312_1110_0302_0100, 64'h1716_1514_0706_0504,
    64'h0,                   64'h00FF_00FF_00FF_00FF,
    64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_FFFF_0000};
  localparam logic        T_ERR [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic [1:0]  lane_size;
  logic        upper_sel;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_size_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkilv_unit u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_a        (src_a),
    .src_b        (src_b),
    .lane_size    (lane_size),
    .upper_sel    (upper_sel),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_size_err (out_size_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] s, input logic u);
    @(negedge clk);
    in_valid  = v;
    src_a     = a;
    src_b     = b;
    lane_size = s;
    upper_sel = u;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; src_a = '0; src_b = '0; lane_size = '0; upper_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {63'b0, out_valid}, 64'd0);
    chk("R1 out_data in reset", out_data, 64'd0);
    chk("R1 out_size_err in reset", {63'b0, out_size_err}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_data after release", out_data, 64'd0);
    chk("R1 out_valid after release", {63'b0, out_valid}, 64'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      drive(1'b1, T_A[i], T_B[i], T_S[i], T_U[i]);
      drive(1'b0, ~T_A[i], ~T_B[i], ~T_S[i], ~T_U[i]);
      if (T_ERR[i]) tag = $sformatf("R7 vec %0d", i);
      else if (T_U[i]) tag = $sformatf("R3 R5 vec %0d", i);
      else tag = $sformatf("R3 R4 vec %0d", i);
      chk({tag, " data"}, out_data, T_E[i]);
      chk({tag, " err"}, {63'b0, out_size_err}, {63'b0, T_ERR[i]});
      chk("R2 valid after request", {63'b0, out_valid}, 64'd1);
      @(negedge clk);
      chk("R2 valid low after idle", {63'b0, out_valid}, 64'd0);
      chk("R8 data held while idle", out_data, T_E[i]);
      chk("R8 err held while idle", {63'b0, out_size_err}, {63'b0, T_ERR[i]});
    end

    // R6: all-zero result overwrites an all-ones result
    drive(1'b1, ONES, ONES, 2'd2, 1'b0);
    drive(1'b1, 64'h0, 64'h0, 2'd0, 1'b1);
    chk("R6 all ones first", out_data, ONES);
    drive(1'b0, ONES, ONES, 2'd1, 1'b0);
    chk("R6 zero overwrites", out_data, 64'h0);

    // R7 with upper half, then recovery to legal width
    drive(1'b1, VA, VB, 2'd3, 1'b1);
    drive(1'b1, VA, VB, 2'd1, 1'b1);
    chk("R7 illegal upper data", out_data, 64'h0);
    chk("R7 illegal upper err", {63'b0, out_size_err}, 64'd1);
    drive(1'b0, 64'h0, 64'h0, 2'd0, 1'b0);
    chk("R7 err clears on legal width", {63'b0, out_size_err}, 64'd0);
    chk("R3 R5 back-to-back data", out_data, 64'h1716_0706_1514_0504);
    chk("R2 back-to-back valid", {63'b0, out_valid}, 64'd1);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears data", out_data, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule